// File: doc/BRIEF.md
# Entropy Slice Random Number Controller

This block takes a 128-bit raw entropy bus and builds 64-bit random numbers from it. One byte of the entropy bus is chosen by a 4-bit slice code. While generation is allowed, that byte is captured once per clock into an assembly register. After eight captures the full word moves into an output register and is marked ready. Software drives a 9-bit control word through a single write strobe. The fields are: entropy enable, delivery enable, generator reset, exported-entropy mode and slice code.

Two events re-arm a warm-up counter: releasing the generator reset, and changing the exported-entropy mode. While that counter runs, no bytes are captured. The counter length depends on the mode: 80 clocks when exported entropy is on, 730 clocks when it is off. Consumers read the output register at 8, 16, 32 or 64 bits. A wider request gives zero and raises a fault. A read made when no word is ready gives the last word again and raises a not-ready flag.

Top module: `rng_entropy_ctrl`

## Requirements
- R1: After reset, `num_ready` and `warming` are 0, and a 64-bit read returns 0 with `rd_not_ready` set.
- R2: The control word is decoded as follows: bit 0 entropy enable, bit 1 delivery enable, bit 3 generator reset, bit 4 exported-entropy mode, bits 8:5 slice code. Bit 2 is unused.
- R3: Slice code n captures entropy bits 8n+7 down to 8n.
- R4: A word is assembled from eight captures on consecutive clock edges. The first capture lands in bits 7:0 and later captures fill higher bytes in order. `num_ready` rises on the edge of the eighth capture.
- R5: While generator reset is 1, the partial word is discarded and nothing is captured. After release and warm-up, a full eight fresh captures are needed before `num_ready` rises.
- R6: A write that changes generator reset from 1 to 0 starts a warm-up of 730 clocks in mode 0 and 80 clocks in mode 1. `warming` is 1 for exactly that many cycles after the write edge.
- R7: A write that changes the mode from 0 to 1 starts an 80-clock warm-up. A change from 1 to 0 starts a 730-clock warm-up.
- R8: No byte is captured while `warming` is 1. The first capture happens on the clock edge right after `warming` drops.
- R9: With entropy enable 0, nothing is captured. With delivery enable 0, assembly stops after seven bytes and no word is delivered. Setting delivery enable completes the word on the next edge.
- R10: For `rd_size` 0, 1, 2 and 3, the read returns the low 8, 16, 32 or 64 bits of the output word, zero-extended, one cycle after `rd_req`. A read of a ready word clears `num_ready`.
- R11: For `rd_size` 4 to 7, the read returns 0 with `rd_fault` set, and `num_ready` is left unchanged.
- R12: A legal read when no word is ready returns the last delivered word with `rd_not_ready` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 9 | Control word (layout in R2) |
| ent_data | input | 128 | Raw entropy bus |
| rd_req | input | 1 | Read request |
| rd_size | input | 3 | Access width code (0:8, 1:16, 2:32, 3:64, 4-7: too wide) |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 64 | Read response data |
| rd_fault | output | 1 | Access wider than 64 bits |
| rd_not_ready | output | 1 | Read served while no word was ready |
| num_ready | output | 1 | A delivered word waits to be read |
| warming | output | 1 | Warm-up counter running |

## Verification
A control write takes effect on its capture edge. `warming` is then high on exactly N following negedge samples, and the bench counts those samples against 80 or 730. The first byte is captured on the edge after `warming` falls, so `num_ready` is due at the eighth edge after that point. The bench checks it is still low at the seventh sample and high at the eighth. Read responses are due one edge after the request, and the bench samples them on the following negedge. Releasing delivery enable completes the stalled word one edge after the write edge, so it is checked at the second negedge.

// File: rtl/rng_ctrl_pkg.sv
package rng_ctrl_pkg;

  localparam int WORD_W = 64;

  // Control word layout; positions are software-visible.
  typedef struct packed {
    logic [3:0] slice;     // bits 8:5
    logic       exp_mode;  // bit 4
    logic       gen_rst;   // bit 3
    logic       unused2;   // bit 2
    logic       out_en;    // bit 1
    logic       ent_en;    // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // Warm-up length chosen by the mode that follows the write.
  function automatic int warm_len(input logic mode, input int fast, input int slow);
    return mode ? fast : slow;
  endfunction

  // Bits kept for a given access width code; zero for illegal widths.
  function automatic logic [WORD_W-1:0] size_mask(input logic [2:0] sz);
    case (sz)
      3'd0:    return 64'h0000_0000_0000_00FF;
      3'd1:    return 64'h0000_0000_0000_FFFF;
      3'd2:    return 64'h0000_0000_FFFF_FFFF;
      3'd3:    return 64'hFFFF_FFFF_FFFF_FFFF;
      default: return '0;
    endcase
  endfunction

  function automatic logic size_legal(input logic [2:0] sz);
    return sz < 3'd4;
  endfunction

endpackage

// File: rtl/rng_ctrl_regs.sv
module rng_ctrl_regs
  import rng_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl_q,
  output logic              arm,
  output logic              arm_mode
);
  ctrl_t nxt;
  logic  rst_release;
  logic  mode_flip;

  always_comb begin
    nxt         = ctrl_t'(wdata);
    rst_release = ctrl_q.gen_rst && !nxt.gen_rst;
    mode_flip   = ctrl_q.exp_mode != nxt.exp_mode;
    arm         = we && (rst_release || mode_flip);
    arm_mode    = nxt.exp_mode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  ctrl_q <= '0;
    else if (we) ctrl_q <= nxt;
  end
endmodule

// File: rtl/rng_warmup.sv
module rng_warmup
  import rng_ctrl_pkg::*;
#(
  parameter int FAST_CYC = 80,
  parameter int SLOW_CYC = 730,
  localparam int CW = $clog2(SLOW_CYC + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          arm_mode,
  input  logic          hold,
  output logic [CW-1:0] cnt_q,
  output logic          busy
);
  logic [CW-1:0] load_val;

  assign load_val = CW'(warm_len(arm_mode, FAST_CYC, SLOW_CYC));
  assign busy     = cnt_q != '0;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (arm)        cnt_q <= load_val;
    else if (hold)       cnt_q <= '0;
    else if (busy)       cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/rng_assembler.sv
module rng_assembler
  import rng_ctrl_pkg::*;
#(
  parameter int ENT_W  = 128,
  parameter int BYTE_W = 8,
  localparam int SLICES = ENT_W / BYTE_W,
  localparam int BYTES  = WORD_W / BYTE_W,
  localparam int BC_W   = $clog2(BYTES)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ENT_W-1:0]  ent,
  input  logic [3:0]        sel,
  input  logic              ent_en,
  input  logic              out_en,
  input  logic              cancel,
  input  logic              warm_busy,
  input  logic              consume,
  output logic              push,
  output logic              word_done,
  output logic [BC_W-1:0]   byte_cnt,
  output logic [WORD_W-1:0] word_q,
  output logic              ready_q
);
  logic [BYTE_W-1:0] slc [SLICES];
  logic [BYTE_W-1:0] pick;
  logic [BYTES-1:0][BYTE_W-1:0] asm_q, asm_nxt;
  logic last_byte;

  for (genvar g = 0; g < SLICES; g++) begin : g_slice
    assign slc[g] = ent[g*BYTE_W +: BYTE_W];
  end

  assign pick      = slc[sel];
  assign last_byte = byte_cnt == BC_W'(BYTES - 1);
  assign push      = ent_en && !cancel && !warm_busy && !(last_byte && !out_en);
  assign word_done = push && last_byte;

  always_comb begin
    asm_nxt           = asm_q;
    asm_nxt[byte_cnt] = pick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_q    <= '0;
      byte_cnt <= '0;
      word_q   <= '0;
      ready_q  <= 1'b0;
    end else begin
      if (cancel)    byte_cnt <= '0;
      else if (push) byte_cnt <= byte_cnt + BC_W'(1);
      if (push) asm_q <= asm_nxt;
      if (word_done) word_q <= asm_nxt;
      if (word_done)    ready_q <= 1'b1;
      else if (consume) ready_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rng_read_port.sv
module rng_read_port
  import rng_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [2:0]        size,
  input  logic [WORD_W-1:0] word,
  input  logic              ready,
  output logic              consume,
  output logic              valid_q,
  output logic [WORD_W-1:0] data_q,
  output logic              fault_q,
  output logic              not_ready_q
);
  logic legal;

  assign legal   = size_legal(size);
  assign consume = req && legal && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q     <= 1'b0;
      data_q      <= '0;
      fault_q     <= 1'b0;
      not_ready_q <= 1'b0;
    end else begin
      valid_q     <= req;
      fault_q     <= req && !legal;
      not_ready_q <= req && legal && !ready;
      if (req) data_q <= word & size_mask(size);
    end
  end
endmodule

// File: rtl/rng_entropy_ctrl.sv
module rng_entropy_ctrl
  import rng_ctrl_pkg::*;
#(
  parameter int ENT_W    = 128,
  parameter int BYTE_W   = 8,
  parameter int FAST_CYC = 80,
  parameter int SLOW_CYC = 730
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic [ENT_W-1:0]  ent_data,
  input  logic              rd_req,
  input  logic [2:0]        rd_size,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_fault,
  output logic              rd_not_ready,
  output logic              num_ready,
  output logic              warming
);
  localparam int CW   = $clog2(SLOW_CYC + 1);
  localparam int BC_W = $clog2(WORD_W / BYTE_W);

  ctrl_t             ctrl_q;
  logic              arm, arm_mode;
  logic [CW-1:0]     warm_cnt;
  logic              push, word_done, consume;
  logic [BC_W-1:0]   byte_cnt;
  logic [WORD_W-1:0] word_q;

  rng_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .ctrl_q(ctrl_q), .arm(arm), .arm_mode(arm_mode)
  );

  rng_warmup #(.FAST_CYC(FAST_CYC), .SLOW_CYC(SLOW_CYC)) u_warm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .arm_mode(arm_mode),
    .hold(ctrl_q.gen_rst), .cnt_q(warm_cnt), .busy(warming)
  );

  rng_assembler #(.ENT_W(ENT_W), .BYTE_W(BYTE_W)) u_asm (
    .clk(clk), .rst_n(rst_n), .ent(ent_data), .sel(ctrl_q.slice),
    .ent_en(ctrl_q.ent_en), .out_en(ctrl_q.out_en), .cancel(ctrl_q.gen_rst),
    .warm_busy(warming), .consume(consume), .push(push),
    .word_done(word_done), .byte_cnt(byte_cnt), .word_q(word_q),
    .ready_q(num_ready)
  );

  rng_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .size(rd_size),
    .word(word_q), .ready(num_ready), .consume(consume),
    .valid_q(rd_valid), .data_q(rd_data), .fault_q(rd_fault),
    .not_ready_q(rd_not_ready)
  );
endmodule

// File: rtl/rng_entropy_ctrl_chk.sv
module rng_entropy_ctrl_chk #(
  parameter int FAST_CYC = 80,
  parameter int CW       = 10,
  parameter int BC_W     = 3
)(
  input logic            clk,
  input logic            rst_n,
  input logic            arm,
  input logic            arm_mode,
  input logic            gen_rst,
  input logic [CW-1:0]   warm_cnt,
  input logic            warming,
  input logic            push,
  input logic            word_done,
  input logic [BC_W-1:0] byte_cnt,
  input logic            num_ready,
  input logic [2:0]      rd_size,
  input logic            rd_valid,
  input logic [63:0]     rd_data,
  input logic            rd_fault,
  input logic            rd_not_ready
);
  // R6
  arm_starts_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> warming);
  // R7
  fast_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && arm_mode) |=> warm_cnt == CW'(FAST_CYC));
  // R6
  warm_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warming && !arm && !gen_rst) |=> warm_cnt == $past(warm_cnt) - CW'(1));
  // R8
  no_push_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !warming);
  // R5
  cancel_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_rst && $past(gen_rst)) |-> (byte_cnt == '0 && !push));
  // R4
  done_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> num_ready);
  // R11
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> (rd_valid && rd_data == 64'd0));
  // R12
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_fault, rd_not_ready}));
  // R10
  byte_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_size) == 3'd0) |-> rd_data[63:8] == 56'd0);
endmodule

bind rng_entropy_ctrl rng_entropy_ctrl_chk #(.FAST_CYC(FAST_CYC), .CW(CW), .BC_W(BC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .arm_mode(arm_mode),
  .gen_rst(ctrl_q.gen_rst), .warm_cnt(warm_cnt), .warming(warming),
  .push(push), .word_done(word_done), .byte_cnt(byte_cnt),
  .num_ready(num_ready), .rd_size(rd_size), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_fault(rd_fault), .rd_not_ready(rd_not_ready)
);

// File: tb/sim_rng_entropy_ctrl.sv
module sim_rng_entropy_ctrl;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_we = 1'b0;
  logic [8:0]   cfg_wdata = '0;
  logic [127:0] ent_data = '0;
  logic         rd_req = 1'b0;
  logic [2:0]   rd_size = '0;
  logic         rd_valid, rd_fault, rd_not_ready, num_ready, warming;
  logic [63:0]  rd_data;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rng_entropy_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ent_data(ent_data), .rd_req(rd_req), .rd_size(rd_size),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault),
    .rd_not_ready(rd_not_ready), .num_ready(num_ready), .warming(warming)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 29 + 71) & 255);
  endfunction

  function automatic logic [127:0] fill(input int sel, input logic [7:0] v);
    logic [127:0] e;
    for (int i = 0; i < 16; i++) e[i*8 +: 8] = pat(i);
    e[sel*8 +: 8] = v;
    return e;
  endfunction

  // Layout per R2: {slice[3:0], mode, gen_rst, 0, out_en, ent_en}
  task automatic wr(input bit en, input bit oe, input bit gr, input bit md, input int sel);
    cfg_we    = 1'b1;
    cfg_wdata = {4'(sel), md, gr, 1'b0, oe, en};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic count_warm(output int n);
    n = 0;
    while (warming && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [2:0] sz, output logic [63:0] d,
                    output logic f, output logic nr);
    rd_req  = 1'b1;
    rd_size = sz;
    @(negedge clk);
    rd_req = 1'b0;
    chk("R10 valid", 64'(rd_valid), 64'd1);
    d  = rd_data;
    f  = rd_fault;
    nr = rd_not_ready;
  endtask

  task automatic wait_ready;
    for (int i = 0; i < 40 && !num_ready; i++) @(negedge clk);
  endtask

  initial begin
    while (cyc < 150000) @(negedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<150000", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    logic [63:0] d, w, last;
    logic f, nr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ready", 64'(num_ready), 0);
    chk("R1 warming", 64'(warming), 0);
    rd(3'd3, d, f, nr);
    chk("R1 data", d, 0);
    chk("R1 not_ready", 64'(nr), 1);

    // R6 slow warm-up, then R4/R8 byte order
    ent_data = fill(0, 8'h00);
    wr(1, 1, 1, 0, 0);
    wr(1, 1, 0, 0, 0);
    count_warm(n);
    chk("R6 slow len", 64'(n), 730);
    w = '0;
    for (int k = 0; k < 8; k++) begin
      ent_data = fill(0, 8'(k * 37 + 5));
      w[k*8 +: 8] = 8'(k * 37 + 5);
      @(negedge clk);
      if (k == 6) chk("R4 not ready at 7", 64'(num_ready), 0);
    end
    chk("R8 ready at 8", 64'(num_ready), 1);
    rd(3'd3, d, f, nr);
    chk("R4 word order", d, w);
    chk("R10 consume", 64'(num_ready), 0);

    // R7 mode toggles
    wr(1, 1, 0, 1, 0);
    count_warm(n);
    chk("R7 0to1 len", 64'(n), 80);
    wr(1, 1, 0, 0, 0);
    count_warm(n);
    chk("R7 1to0 len", 64'(n), 730);
    // R6 fast release
    wr(1, 1, 1, 1, 0);
    wr(1, 1, 0, 1, 0);
    count_warm(n);
    chk("R6 fast len", 64'(n), 80);

    // R3 / R2 exhaustive slice sweep
    for (int s = 0; s < 16; s++) begin
      ent_data = fill(s, pat(s + 100));
      wr(1, 1, 1, 1, s);
      wr(1, 1, 0, 1, s);
      count_warm(n);
      wait_ready();
      rd(3'd3, d, f, nr);
      chk($sformatf("R3 slice %0d", s), d, {8{pat(s + 100)}});
    end

    // R10 access widths
    ent_data = fill(5, 8'hC6);
    wr(1, 1, 1, 1, 5);
    wr(1, 1, 0, 1, 5);
    count_warm(n);
    for (int sz = 0; sz < 4; sz++) begin
      wait_ready();
      rd(3'(sz), d, f, nr);
      chk($sformatf("R10 size %0d", sz), d,
          {8{8'hC6}} & ((sz == 3) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 << sz)) - 1)));
      chk("R10 no fault", 64'(f), 0);
    end

    // R11 too-wide reads
    wait_ready();
    for (int sz = 4; sz < 8; sz++) begin
      rd(3'(sz), d, f, nr);
      chk($sformatf("R11 data %0d", sz), d, 0);
      chk("R11 fault", 64'(f), 1);
      chk("R11 ready kept", 64'(num_ready), 1);
    end

    // R12 and R9 entropy enable off
    wr(0, 1, 0, 1, 5);
    rd(3'd3, last, f, nr);
    repeat (30) @(negedge clk);
    chk("R9 ent off", 64'(num_ready), 0);
    rd(3'd3, d, f, nr);
    chk("R12 last value", d, last);
    chk("R12 not_ready", 64'(nr), 1);

    // R9 delivery enable off, then on
    ent_data = fill(5, 8'h3B);
    wr(1, 0, 1, 1, 5);
    wr(1, 0, 0, 1, 5);
    count_warm(n);
    repeat (20) @(negedge clk);
    chk("R9 out off", 64'(num_ready), 0);
    wr(1, 1, 0, 1, 5);
    chk("R9 not yet", 64'(num_ready), 0);
    @(negedge clk);
    chk("R9 resumed", 64'(num_ready), 1);
    rd(3'd3, d, f, nr);
    chk("R9 word", d, {8{8'h3B}});

    // R5 cancel discards partial word
    repeat (3) @(negedge clk);
    wr(1, 1, 1, 1, 5);
    repeat (20) @(negedge clk);
    chk("R5 held ready", 64'(num_ready), 0);
    chk("R5 held warming", 64'(warming), 0);
    wr(1, 1, 0, 1, 5);
    count_warm(n);
    repeat (7) @(negedge clk);
    chk("R5 not ready at 7", 64'(num_ready), 0);
    @(negedge clk);
    chk("R5 ready at 8", 64'(num_ready), 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule